// File: doc/BRIEF.md
# Programmable Clock Divider with Phase Control

This block divides a fast clock by any integer from 1 to 32. The high part and the low part of each output period are set by two separate counts, so the duty cycle is a free choice. A starting phase offset and a starting level decide where the output waveform begins. A realign request puts the divider into a known state. Several copies of the block that share one fast clock therefore line up again when they see the same request.

The phase offset and the start level have no effect while the divider runs. They are sampled only on a clock edge where a realign is applied. While the request is held, the output sits at the start level. After the request is released, the divider waits for the number of fast-clock cycles given by the offset and then alternates between the two levels. Each copy has an ignore bit, so a copy can keep running through a realign meant for others. Bypass sends the fast clock straight to the output; this is the only way to get division by 1.

Top module: `clkdiv_phase`

## Requirements
- R1: The count byte holds the low count in bits 7:4 and the high count in bits 3:0. The output period equals (low+1)+(high+1) fast-clock cycles. All-zero gives 2 and both fields at 15 give 32.
- R2: Outside a realign, each high part of the output lasts high+1 cycles and each low part lasts low+1 cycles. For example, low=2 and high=5 give 6 high cycles out of 9.
- R3: With bypass set to 1, `clk_o` follows `clk_i` in both clock phases.
- R4: On each rising edge where `sync_i`=1 and `nosync_i`=0, the output takes the value of `start_hi_i` (1 = high, 0 = low). It keeps taking that value on every such edge while the request is held.
- R5: After the last realign edge, the output stays at the start level for P + L cycles and then alternates. P is the effective offset and L is the start level's own count plus 1.
- R6: An offset equal to or above the period wraps: the effective offset P is the offset modulo the period.
- R7: Changes of `phase_i` and `start_hi_i` between realign edges have no effect on the output.
- R8: With `nosync_i`=1, `sync_i` has no effect and the divider keeps its running pattern.
- R9: While `rst_ni`=0 the divided output is low. The first rising edge after release loads the settings exactly as a realign edge would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Realign request, active high, sampled on rising edges |
| nosync_i | input | 1 | 1 = this divider ignores the realign request |
| bypass_i | input | 1 | 1 = route `clk_i` straight to `clk_o` (divide by 1) |
| div_cfg_i | input | 8 | Count byte: low count in 7:4, high count in 3:0 |
| phase_i | input | 4 | Starting offset in fast-clock cycles |
| start_hi_i | input | 1 | Start level: 1 = high, 0 = low |
| clk_o | output | 1 | Divided clock |

## Verification
A realign can arrive on the same edge where the running count would have toggled the output, or where the offset wait would have ended. The load must win, and the count must restart from the start level. The bench provokes this collision in two ways. Directed realigns land at several points of a period, and randomly timed realign pulses cover the rest. After every edge, `clk_o` is compared with a waveform built from the last realign edge: the effective offset, the start level and the two run lengths. A load that lost the collision leaves an extra or a shortened run, and the comparison flags it. The bench also changes the offset and start inputs between realigns. The comparison shows that a late change cannot be mistaken for a load.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Sequencer mode: waiting to load, burning offset cycles, or toggling.
    typedef enum logic [1:0] {
        SQ_LOAD  = 2'd0,
        SQ_SKIP  = 2'd1,
        SQ_COUNT = 2'd2
    } sq_mode_e;

endpackage

// File: rtl/clkdiv_lenc.sv
// Splits the count byte and reduces the offset modulo the period.
module clkdiv_lenc #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned PH_W  = 4
) (
    input  logic [2*CNT_W-1:0] div_cfg_i,
    input  logic [PH_W-1:0]    phase_i,
    output logic [CNT_W-1:0]   hi_f_o,
    output logic [CNT_W-1:0]   lo_f_o,
    output logic [PH_W-1:0]    ph_wrap_o
);
    localparam int unsigned MW   = ((PH_W > CNT_W) ? PH_W : CNT_W) + 2;
    // Shortest period is 2, so this many subtractions always reach the residue.
    localparam int unsigned NSTG = (2 ** PH_W) / 2;

    logic [MW-1:0] ratio;
    logic [MW-1:0] acc;

    always_comb begin
        hi_f_o = div_cfg_i[CNT_W-1:0];
        lo_f_o = div_cfg_i[2*CNT_W-1:CNT_W];
        ratio  = MW'(div_cfg_i[CNT_W-1:0]) + MW'(div_cfg_i[2*CNT_W-1:CNT_W]) + MW'(2);
        acc    = {{(MW-PH_W){1'b0}}, phase_i};
        for (int i = 0; i < NSTG; i++) begin
            if (acc >= ratio) begin
                acc = acc - ratio;
            end
        end
        ph_wrap_o = acc[PH_W-1:0];
    end
endmodule

// File: rtl/clkdiv_seq.sv
// Level sequencer: load on realign, wait out the offset, then alternate.
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned PH_W  = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             apply_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] hi_f_i,
    input  logic [CNT_W-1:0] lo_f_i,
    input  logic [PH_W-1:0]  skip_i,
    output logic             lvl_o
);
    typedef struct packed {
        sq_mode_e         mode;
        logic             lvl;
        logic [CNT_W-1:0] cnt;
        logic [PH_W-1:0]  skip;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.mode == SQ_LOAD || apply_i) begin
            st_d.lvl  = start_i;
            st_d.cnt  = start_i ? hi_f_i : lo_f_i;
            st_d.skip = skip_i;
            st_d.mode = (skip_i != '0) ? SQ_SKIP : SQ_COUNT;
        end else if (st_q.mode == SQ_SKIP) begin
            st_d.skip = st_q.skip - PH_W'(1);
            if (st_q.skip == PH_W'(1)) begin
                st_d.mode = SQ_COUNT;
            end
        end else if (st_q.cnt == '0) begin
            st_d.lvl = ~st_q.lvl;
            st_d.cnt = st_q.lvl ? lo_f_i : hi_f_i;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: SQ_LOAD, lvl: 1'b0, cnt: '0, skip: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;
endmodule

// File: rtl/clkdiv_outsel.sv
// Output select: divided level or the raw fast clock.
module clkdiv_outsel (
    input  logic clk_i,
    input  logic lvl_i,
    input  logic bypass_i,
    output logic clk_o
);
    always_comb begin
        clk_o = bypass_i ? clk_i : lvl_i;
    end
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned PH_W  = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sync_i,
    input  logic               nosync_i,
    input  logic               bypass_i,
    input  logic [2*CNT_W-1:0] div_cfg_i,
    input  logic [PH_W-1:0]    phase_i,
    input  logic               start_hi_i,
    output logic               clk_o
);
    logic             apply;
    logic [CNT_W-1:0] hi_f;
    logic [CNT_W-1:0] lo_f;
    logic [PH_W-1:0]  ph_wrap;
    logic             div_lvl;

    assign apply = sync_i & ~nosync_i;

    clkdiv_lenc #(.CNT_W(CNT_W), .PH_W(PH_W)) u_lenc (
        .div_cfg_i (div_cfg_i),
        .phase_i   (phase_i),
        .hi_f_o    (hi_f),
        .lo_f_o    (lo_f),
        .ph_wrap_o (ph_wrap)
    );

    clkdiv_seq #(.CNT_W(CNT_W), .PH_W(PH_W)) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .apply_i (apply),
        .start_i (start_hi_i),
        .hi_f_i  (hi_f),
        .lo_f_i  (lo_f),
        .skip_i  (ph_wrap),
        .lvl_o   (div_lvl)
    );

    clkdiv_outsel u_outsel (
        .clk_i    (clk_i),
        .lvl_i    (div_lvl),
        .bypass_i (bypass_i),
        .clk_o    (clk_o)
    );
endmodule

// File: rtl/clkdiv_phase_chk.sv
module clkdiv_phase_chk #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned PH_W  = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               sync_i,
    input logic               nosync_i,
    input logic               start_hi_i,
    input logic [2*CNT_W-1:0] div_cfg_i,
    input logic               div_lvl
);
    localparam int unsigned RUN_W   = ((CNT_W > PH_W) ? CNT_W : PH_W) + 2;
    localparam int unsigned MAX_RUN = (2 ** PH_W - 1) + 2 ** CNT_W;

    logic             ld_now;
    logic             pend_q;
    logic             app_q;
    logic             lvl_q;
    logic             cln_q;
    logic [RUN_W-1:0] run_q;
    logic             edge_seen;

    assign ld_now    = sync_i & ~nosync_i;
    assign edge_seen = (div_lvl != lvl_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= 1'b1;
            app_q  <= 1'b1;
            lvl_q  <= 1'b0;
            cln_q  <= 1'b0;
            run_q  <= '0;
        end else begin
            pend_q <= 1'b0;
            app_q  <= ld_now | pend_q;
            lvl_q  <= div_lvl;
            if (edge_seen || app_q) begin
                run_q <= RUN_W'(1);
                cln_q <= edge_seen & ~app_q;
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

    AST_SYNC_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && !nosync_i) |=> (div_lvl == $past(start_hi_i))); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && !nosync_i && $past(sync_i && !nosync_i) && (start_hi_i == $past(start_hi_i)))
        |=> $stable(div_lvl)); // R4

    AST_HIGH_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_seen && !app_q && cln_q && lvl_q)
        |-> (run_q == RUN_W'(div_cfg_i[CNT_W-1:0]) + RUN_W'(1))); // R2

    AST_LOW_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_seen && !app_q && cln_q && !lvl_q)
        |-> (run_q == RUN_W'(div_cfg_i[2*CNT_W-1:CNT_W]) + RUN_W'(1))); // R2

    AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= RUN_W'(MAX_RUN)); // R5
endmodule

bind clkdiv_phase clkdiv_phase_chk #(.CNT_W(CNT_W), .PH_W(PH_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .nosync_i   (nosync_i),
    .start_hi_i (start_hi_i),
    .div_cfg_i  (div_cfg_i),
    .div_lvl    (div_lvl)
);

// File: tb/clkdiv_phase_tb.sv
`timescale 1ns/1ps
module clkdiv_phase_tb;
    logic       clk_i = 1'b0;
    logic       rst_ni;
    logic       sync_i;
    logic       nosync_i;
    logic       bypass_i;
    logic [7:0] div_cfg_i;
    logic [3:0] phase_i;
    logic       start_hi_i;
    logic       clk_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // bench model state: edges since last load, effective offset, start level
    int k     = 0;
    int s_m   = 0;
    bit st_m  = 0;
    bit pend_m = 0;

    always #10 clk_i = ~clk_i;

    clkdiv_phase u_dut (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_i     (sync_i),
        .nosync_i   (nosync_i),
        .bypass_i   (bypass_i),
        .div_cfg_i  (div_cfg_i),
        .phase_i    (phase_i),
        .start_hi_i (start_hi_i),
        .clk_o      (clk_o)
    );

    function automatic bit exp_lvl(int kk, int s, bit st, int cfg);
        int lo = (cfg >> 4) & 15;
        int hi = cfg & 15;
        int l0 = st ? hi + 1 : lo + 1;
        int l1 = st ? lo + 1 : hi + 1;
        int m;
        if (kk < s + l0) return st;
        m = (kk - s - l0) % (l0 + l1);
        return (m < l1) ? !st : st;
    endfunction

    function automatic int eff_phase(int ph, int cfg);
        return ph % ((((cfg >> 4) & 15) + 1) + ((cfg & 15) + 1));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; drives sync, advances one rising edge, checks.
    task automatic step(input logic s_in, input string req);
        sync_i = s_in;
        @(posedge clk_i);
        if (pend_m || (s_in && !nosync_i)) begin
            pend_m = 0;
            k      = 0;
            s_m    = eff_phase(int'(phase_i), int'(div_cfg_i));
            st_m   = start_hi_i;
        end else begin
            k++;
        end
        @(negedge clk_i);
        if (!bypass_i) chk(req, int'(clk_o), int'(exp_lvl(k, s_m, st_m, int'(div_cfg_i))));
    endtask

    // First realign edge with the old settings, then new settings for the rest.
    task automatic realign(input int cfg, input int ph, input bit st,
                           input int hold, input string req);
        step(1'b1, req);
        div_cfg_i  = 8'(cfg);
        phase_i    = 4'(ph);
        start_hi_i = st;
        for (int i = 1; i < hold; i++) step(1'b1, req);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int hcnt;
        void'($urandom(32'h5EED_C10C));
        rst_ni     = 1'b0;
        sync_i     = 1'b0;
        nosync_i   = 1'b0;
        bypass_i   = 1'b0;
        div_cfg_i  = 8'h25;   // low=2, high=5, period 9
        phase_i    = 4'd0;
        start_hi_i = 1'b1;

        // R9: output low throughout reset
        repeat (3) begin
            @(negedge clk_i);
            chk("R9", int'(clk_o), 0);
        end
        rst_ni = 1'b1;
        pend_m = 1;
        for (int i = 0; i < 9; i++) step(1'b0, "R9");

        // R2: 6 of 9 cycles high
        hcnt = 0;
        for (int i = 0; i < 36; i++) begin
            step(1'b0, "R2");
            hcnt += int'(clk_o);
        end
        chk("R2", hcnt, 24);

        // R1: longest and shortest period, asymmetric counts
        realign(8'hFF, 0, 1'b0, 2, "R1");
        hcnt = 0;
        for (int i = 0; i < 64; i++) begin
            step(1'b0, "R1");
            hcnt += int'(clk_o);
        end
        chk("R1", hcnt, 32);
        realign(8'h00, 0, 1'b1, 2, "R1");
        for (int i = 0; i < 12; i++) step(1'b0, "R1");
        realign(8'hF0, 0, 1'b1, 2, "R1");
        for (int i = 0; i < 40; i++) step(1'b0, "R1");

        // R5: offset delays the first edge
        realign(8'h11, 3, 1'b0, 2, "R5");
        for (int i = 0; i < 20; i++) step(1'b0, "R5");
        realign(8'h3A, 9, 1'b1, 3, "R5");
        for (int i = 0; i < 40; i++) step(1'b0, "R5");

        // R6: offsets beyond the period wrap
        realign(8'h00, 15, 1'b1, 2, "R6");
        for (int i = 0; i < 10; i++) step(1'b0, "R6");
        realign(8'h01, 14, 1'b0, 2, "R6");
        for (int i = 0; i < 12; i++) step(1'b0, "R6");

        // R4: long hold with the start level flipping each edge
        realign(8'h42, 1, 1'b0, 2, "R4");
        for (int i = 0; i < 6; i++) begin
            start_hi_i = ~start_hi_i;
            step(1'b1, "R4");
        end
        for (int i = 0; i < 20; i++) step(1'b0, "R4");

        // R4: realign landing on every position of a period (collision cases)
        for (int p = 0; p < 7; p++) begin
            realign(8'h24, 2, 1'b1, 2, "R4");
            for (int i = 0; i < p; i++) step(1'b0, "R4");
        end
        for (int i = 0; i < 16; i++) step(1'b0, "R4");

        // R7: offset and start changes between realigns are ignored
        realign(8'h13, 1, 1'b1, 2, "R7");
        for (int i = 0; i < 30; i++) begin
            step(1'b0, "R7");
            phase_i    = 4'($urandom);
            start_hi_i = 1'($urandom);
        end

        // R8: ignore bit keeps the pattern through a request
        nosync_i = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b1, "R8");
        for (int i = 0; i < 20; i++) step(1'b0, "R8");
        nosync_i = 1'b0;

        // R3: bypass routes the fast clock
        bypass_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_i);
            #5 chk("R3", int'(clk_o), 1);
            @(negedge clk_i);
            #5 chk("R3", int'(clk_o), 0);
        end
        @(negedge clk_i);
        bypass_i = 1'b0;
        realign(8'h21, 2, 1'b0, 2, "R3");
        for (int i = 0; i < 12; i++) step(1'b0, "R3");

        // Random mix: realigns of random length, perturbations, ignore bit
        for (int it = 0; it < 40; it++) begin
            realign(int'($urandom % 256), int'($urandom % 16), 1'($urandom),
                    2 + int'($urandom % 3), "R7");
            for (int i = 0; i < 10 + int'($urandom % 50); i++) begin
                if ($urandom % 8 == 0) begin
                    nosync_i = 1'b1;
                    step(1'b1, "R8");
                    nosync_i = 1'b0;
                end else begin
                    step(1'b0, "R7");
                end
                if ($urandom % 4 == 0) begin
                    phase_i    = 4'($urandom);
                    start_hi_i = 1'($urandom);
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule